// File: doc/BRIEF.md
# Parallel-Port Expansion Bus Bridge

This block turns the printer-port pins into a narrow peripheral bus for an external add-on adapter. When the bridge mode is selected, a host write to the base-address register latches the new base and broadcasts it on the port data lines. During the broadcast both the adapter read and write strobes are held low together, so the adapter can capture the value as its own base.

After that, every host I/O cycle that falls inside the adapter's address window becomes a strobed cycle on the port. A read produces a read strobe, and a write produces a write strobe with the host data driven outward. The three low address bits are passed through. The window is 8 bytes wide, or 16 bytes when a control input widens it. The adapter interrupt, DMA request, DMA acknowledge and terminal count are routed through while the mode is active.

All host inputs are sampled on `clk_i`. Strobes, the adapter address and the outward data are registered, so they appear one cycle after the sampling edge. The pass-through signals are combinational.

Top module: `xbus_bridge`

## Requirements
- R1: The bridge is active only when `bridge_dis_i` is 0 and `mode_fld_i` equals 2'b10. While it is inactive, a base write changes nothing and starts no broadcast, host cycles produce no strobe, `irq7_o`, `drq_o` and `xtc_o` are 0, and `xdack_no` is 1.
- R2: A base write (`base_wr_i` high while active) stores `sd_i`. Bits [7:1] of the stored byte become the window base EA[9:3]. For the next `BCAST_CYC` cycles (default 4) after the sampling edge, `xrd_no` and `xwr_no` are both 0, `xd_oe_o` is 1 and `xd_o` carries the stored byte.
- R3: With `win_wide_i` = 0, a host cycle hits when SA[9:3] equals EA[9:3].
- R4: With `win_wide_i` = 1, only SA[9:4] is compared against EA[9:4], which gives a 16-byte window.
- R5: A hit with `ior_ni` = 0 and `iow_ni` = 1 makes `xrd_no` 0 in the following cycle. In that cycle `xd_oe_o` is 0, `sd_oe_o` is 1 and `sd_o` follows `xd_i`.
- R6: A hit with `iow_ni` = 0 and `ior_ni` = 1 makes `xwr_no` 0 in the following cycle. In that cycle `xd_oe_o` is 1 and `xd_o` equals the sampled `sd_i`.
- R7: `xa_o` takes SA[2:0] of the most recent strobed host cycle.
- R8: A host cycle sampled with `aen_i` = 1 produces no strobe.
- R9: After reset the base is zero and not valid, and no host cycle produces a strobe until a base has been written.
- R10: While active, `irq7_o` follows the active-high adapter interrupt `xirq_i`.
- R11: While active, `drq_o` follows `xdrq_i`, `xdack_no` follows `dack_ni` and `xtc_o` follows `tc_i`.
- R12: A host cycle sampled together with a base write, or while a broadcast is still pending, produces no separate strobe. In that case `sd_oe_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bridge_dis_i | input | 1 | Mode bit; must be 0 for the bridge to be active |
| mode_fld_i | input | 2 | Port mode field; 2'b10 selects the bridge |
| win_wide_i | input | 1 | 1 selects the 16-byte window compare |
| base_wr_i | input | 1 | Host write to the base-address register |
| sa_i | input | 10 | Host address |
| sd_i | input | 8 | Host write data |
| sd_o | output | 8 | Read data returned to the host |
| sd_oe_o | output | 1 | Host data drive enable |
| ior_ni | input | 1 | Host I/O read, active low |
| iow_ni | input | 1 | Host I/O write, active low |
| aen_i | input | 1 | Host DMA address enable |
| dack_ni | input | 1 | Host DMA acknowledge, active low |
| tc_i | input | 1 | Host terminal count |
| drq_o | output | 1 | DMA request to the host |
| irq7_o | output | 1 | Interrupt to host line 7 |
| xrd_no | output | 1 | Adapter read strobe, active low |
| xwr_no | output | 1 | Adapter write strobe, active low |
| xa_o | output | 3 | Adapter address |
| xd_i | input | 8 | Adapter data in |
| xd_o | output | 8 | Adapter data out |
| xd_oe_o | output | 1 | Adapter data drive enable |
| xdrq_i | input | 1 | Adapter DMA request |
| xirq_i | input | 1 | Adapter interrupt, active high |
| xdack_no | output | 1 | Adapter DMA acknowledge, active low |
| xtc_o | output | 1 | Adapter terminal count |

## Verification
The bench aims addresses that differ from the base only in SA[3]. A design that ignores the wide control, or compares the wrong slice, either misses these cycles or strobes them under the narrow setting. It also issues reads at the base before any base has been written; a design without the valid flag would strobe on address zero. A host read is placed on the same edge as a base write: a design without broadcast priority would give a read strobe mixed with the broadcast and turn the host data drive on. Base writes are also issued while the mode is inactive; a design that accepted them would broadcast and move the window.

// File: rtl/xb_pkg.sv
package xb_pkg;
  localparam logic [1:0] MODE_BRIDGE = 2'b10;
  typedef enum logic [1:0] {OP_NONE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2} xb_op_e;
endpackage

// File: rtl/xb_window_cmp.sv
module xb_window_cmp #(
  parameter int ADDR_W = 10,
  parameter int XA_W   = 3,
  localparam int BASE_W = ADDR_W - XA_W
) (
  input  logic [ADDR_W-1:0] sa_i,
  input  logic [BASE_W-1:0] ea_i,
  input  logic              wide_i,
  output logic              match_o
);
  logic [BASE_W-1:0] mask;
  logic [BASE_W-1:0] diff;

  // wide mode drops the lowest base bit from the compare
  always_comb begin
    mask    = '1;
    mask[0] = ~wide_i;
    diff    = sa_i[ADDR_W-1:XA_W] ^ ea_i;
    match_o = ((diff & mask) == '0);
  end
endmodule

// File: rtl/xb_bcast_ctl.sv
module xb_bcast_ctl #(
  parameter int BCAST_CYC = 4,
  localparam int CNT_W = $clog2(BCAST_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o,
  output logic busy_nxt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load_i)              cnt_d = CNT_W'(BCAST_CYC);
    else if (cnt_q != '0)    cnt_d = cnt_q - CNT_W'(1);
    else                     cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign busy_o     = (cnt_q != '0);
  assign busy_nxt_o = (cnt_d != '0);

  a_r2_bcast_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i |=> busy_o));
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q <= CNT_W'(BCAST_CYC)));
endmodule

// File: rtl/xb_cycle_gen.sv
module xb_cycle_gen
  import xb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int XA_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic              block_i,
  input  logic              ior_ni,
  input  logic              iow_ni,
  input  logic [XA_W-1:0]   sa_lo_i,
  input  logic [DATA_W-1:0] sd_i,
  output logic              rd_o,
  output logic              wr_o,
  output logic [XA_W-1:0]   xa_o,
  output logic [DATA_W-1:0] wdata_o
);
  xb_op_e op;

  always_comb begin
    op = OP_NONE;
    if (hit_i && !block_i) begin
      if (!ior_ni && iow_ni)      op = OP_RD;
      else if (!iow_ni && ior_ni) op = OP_WR;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_o    <= 1'b0;
      wr_o    <= 1'b0;
      xa_o    <= '0;
      wdata_o <= '0;
    end else begin
      rd_o <= (op == OP_RD);
      wr_o <= (op == OP_WR);
      if (op != OP_NONE) xa_o <= sa_lo_i;
      if (op == OP_WR)   wdata_o <= sd_i;
    end
  end

  a_r12_op_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));
  a_r7_xa_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_i |=> $stable(xa_o)));
endmodule

// File: rtl/xbus_bridge.sv
module xbus_bridge
  import xb_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter int XA_W      = 3,
  parameter int BCAST_CYC = 4,
  localparam int BASE_W   = ADDR_W - XA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bridge_dis_i,
  input  logic [1:0]        mode_fld_i,
  input  logic              win_wide_i,
  input  logic              base_wr_i,
  input  logic [ADDR_W-1:0] sa_i,
  input  logic [DATA_W-1:0] sd_i,
  output logic [DATA_W-1:0] sd_o,
  output logic              sd_oe_o,
  input  logic              ior_ni,
  input  logic              iow_ni,
  input  logic              aen_i,
  input  logic              dack_ni,
  input  logic              tc_i,
  output logic              drq_o,
  output logic              irq7_o,
  output logic              xrd_no,
  output logic              xwr_no,
  output logic [XA_W-1:0]   xa_o,
  input  logic [DATA_W-1:0] xd_i,
  output logic [DATA_W-1:0] xd_o,
  output logic              xd_oe_o,
  input  logic              xdrq_i,
  input  logic              xirq_i,
  output logic              xdack_no,
  output logic              xtc_o
);
  logic              active, load, match, hit;
  logic              vld_q;
  logic [DATA_W-1:0] base_q;
  logic [BASE_W-1:0] ea;
  logic              bc_busy, bc_busy_nxt;
  logic              rd_q, wr_q;
  logic [DATA_W-1:0] wdata_q;

  assign active = !bridge_dis_i && (mode_fld_i == MODE_BRIDGE);
  assign load   = active && base_wr_i;
  assign ea     = base_q[DATA_W-1 -: BASE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      vld_q  <= 1'b0;
    end else if (load) begin
      base_q <= sd_i;
      vld_q  <= 1'b1;
    end
  end

  xb_window_cmp #(.ADDR_W(ADDR_W), .XA_W(XA_W)) i_cmp (
    .sa_i   (sa_i),
    .ea_i   (ea),
    .wide_i (win_wide_i),
    .match_o(match)
  );

  assign hit = active && vld_q && !aen_i && match;

  xb_bcast_ctl #(.BCAST_CYC(BCAST_CYC)) i_bcast (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .busy_o    (bc_busy),
    .busy_nxt_o(bc_busy_nxt)
  );

  xb_cycle_gen #(.DATA_W(DATA_W), .XA_W(XA_W)) i_cyc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .block_i(bc_busy_nxt),
    .ior_ni (ior_ni),
    .iow_ni (iow_ni),
    .sa_lo_i(sa_i[XA_W-1:0]),
    .sd_i   (sd_i),
    .rd_o   (rd_q),
    .wr_o   (wr_q),
    .xa_o   (xa_o),
    .wdata_o(wdata_q)
  );

  assign xrd_no  = !(bc_busy || rd_q);
  assign xwr_no  = !(bc_busy || wr_q);
  assign xd_oe_o = bc_busy || wr_q;
  assign xd_o    = bc_busy ? base_q : wdata_q;
  assign sd_oe_o = rd_q;
  assign sd_o    = xd_i;

  assign irq7_o   = active && xirq_i;
  assign drq_o    = active && xdrq_i;
  assign xtc_o    = active && tc_i;
  assign xdack_no = active ? dack_ni : 1'b1;

  a_r2_bcast_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load |=> (!xrd_no && !xwr_no && xd_oe_o && xd_o == $past(sd_i))));
  a_r8_aen_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((aen_i && !bc_busy_nxt) |=> (xrd_no && xwr_no)));
  a_r9_idle_no_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_q |-> (xrd_no && xwr_no)));
  a_r5_host_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_oe_o |-> (!xrd_no && xwr_no && !xd_oe_o)));
  a_r1_no_load_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!active && !bc_busy_nxt) |=> $stable(base_q)));
endmodule

// File: tb/test_xbus_bridge.sv
module test_xbus_bridge;
  localparam int BC = 4;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       bridge_dis = 1'b1, wide = 1'b0, base_wr = 1'b0;
  logic [1:0] mode_fld = 2'b00;
  logic [9:0] sa = '0;
  logic [7:0] sd = '0, xd_in = '0;
  logic       ior_n = 1'b1, iow_n = 1'b1, aen = 1'b0, dack_n = 1'b1, tc = 1'b0;
  logic       xdrq = 1'b0, xirq = 1'b0;
  logic [7:0] sd_o, xd_o;
  logic       sd_oe, drq, irq7, xrd_n, xwr_n, xd_oe, xdack_n, xtc;
  logic [2:0] xa;

  int n_chk = 0, n_err = 0;
  logic [6:0] ea = '0;
  logic [2:0] exp_xa = '0;

  always #10 clk = ~clk;

  xbus_bridge i_xbus_bridge (
    .clk_i(clk), .rst_ni(rst_ni), .bridge_dis_i(bridge_dis), .mode_fld_i(mode_fld),
    .win_wide_i(wide), .base_wr_i(base_wr), .sa_i(sa), .sd_i(sd), .sd_o(sd_o),
    .sd_oe_o(sd_oe), .ior_ni(ior_n), .iow_ni(iow_n), .aen_i(aen), .dack_ni(dack_n),
    .tc_i(tc), .drq_o(drq), .irq7_o(irq7), .xrd_no(xrd_n), .xwr_no(xwr_n), .xa_o(xa),
    .xd_i(xd_in), .xd_o(xd_o), .xd_oe_o(xd_oe), .xdrq_i(xdrq), .xirq_i(xirq),
    .xdack_no(xdack_n), .xtc_o(xtc)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit win_hit(input logic [9:0] a, input logic [6:0] e, input bit w);
    if (w) return a[9:4] == e[6:1];
    return a[9:3] == e;
  endfunction

  task automatic settle();
    @(posedge clk); #5;
  endtask

  task automatic idle();
    @(negedge clk);
    base_wr = 0; ior_n = 1; iow_n = 1; aen = 0;
  endtask

  task automatic host(input logic [9:0] a, input bit rd, input bit wr, input bit en,
                      input bit w, input bit act, input bit vld, input string tag);
    bit h, er, ew;
    @(negedge clk);
    base_wr = 0; sa = a; ior_n = !rd; iow_n = !wr; aen = en; wide = w;
    sd = 8'($urandom); xd_in = 8'($urandom);
    h  = act && vld && !en && win_hit(a, ea, w);
    er = h && rd && !wr;
    ew = h && wr && !rd;
    if (er || ew) exp_xa = a[2:0];
    settle();
    chk(xrd_n == !er, {tag, " xrd"}, xrd_n, !er);
    chk(xwr_n == !ew, {tag, " xwr"}, xwr_n, !ew);
    chk(xd_oe == ew, {tag, " xd_oe"}, xd_oe, ew);
    chk(sd_oe == er, {tag, " sd_oe (R5)"}, sd_oe, er);
    if (ew) chk(xd_o == sd, {tag, " xd_o (R6)"}, xd_o, sd);
    if (er) chk(sd_o == xd_in, {tag, " sd_o (R5)"}, sd_o, xd_in);
    chk(xa == exp_xa, {tag, " xa (R7)"}, xa, exp_xa);
  endtask

  task automatic bcast(input logic [7:0] v, input bit rd_too);
    @(negedge clk);
    base_wr = 1; sd = v; ior_n = !rd_too; iow_n = 1; aen = 0;
    sa = {ea, 3'd1};
    ea = v[7:1];
    settle();
    for (int i = 0; i < BC; i++) begin
      if (i > 0) settle();
      chk(!xrd_n && !xwr_n, "R2 both strobes low", {xrd_n, xwr_n}, 0);
      chk(xd_oe && xd_o == v, "R2 broadcast data", xd_o, v);
      chk(!sd_oe, "R12 no host drive in broadcast", sd_oe, 0);
      if (i == 0) begin base_wr = 0; ior_n = 1; end
    end
    settle();
    chk(xrd_n && xwr_n && !xd_oe, "R2 broadcast end", {xrd_n, xwr_n, xd_oe}, 3'b110);
  endtask

  task automatic pass_chk(input bit act, input string tag);
    @(negedge clk);
    xirq = 1'($urandom); xdrq = 1'($urandom); tc = 1'($urandom); dack_n = 1'($urandom);
    #2;
    chk(irq7 == (act && xirq), {tag, " R10 irq"}, irq7, act && xirq);
    chk(drq == (act && xdrq), {tag, " R11 drq"}, drq, act && xdrq);
    chk(xtc == (act && tc), {tag, " R11 tc"}, xtc, act && tc);
    chk(xdack_n == (act ? dack_n : 1'b1), {tag, " R11 dack"}, xdack_n, act ? dack_n : 1'b1);
  endtask

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #35 rst_ni = 1;
    settle();
    chk(xrd_n && xwr_n && !xd_oe && !sd_oe, "R9 reset outputs", {xrd_n, xwr_n, xd_oe, sd_oe}, 4'b1100);
    chk(xa == 0, "R9 reset xa", xa, 0);

    // inactive: mode field wrong
    mode_fld = 2'b01; bridge_dis = 0;
    pass_chk(0, "R1 inactive");
    @(negedge clk); base_wr = 1; sd = 8'h6e; settle();
    chk(xrd_n && xwr_n && !xd_oe, "R1 base write ignored", {xrd_n, xwr_n}, 2'b11);
    idle();

    // active, before base written: address 0 must not hit
    mode_fld = 2'b10;
    host(10'h000, 1, 0, 0, 0, 1, 0, "R9 no base yet");
    host(10'h004, 0, 1, 0, 1, 1, 0, "R9 no base yet wr");
    pass_chk(1, "R1 active");

    bcast(8'h6f, 0); // EA = 7'h37 -> base 0x1B8
    host({ea, 3'd5}, 1, 0, 0, 0, 1, 1, "R3 narrow read");
    host({ea, 3'd2}, 0, 1, 0, 0, 1, 1, "R3 narrow write");
    host({ea ^ 7'h01, 3'd6}, 1, 0, 0, 0, 1, 1, "R3 narrow miss bit3");
    host({ea ^ 7'h01, 3'd6}, 1, 0, 0, 1, 1, 1, "R4 wide hit bit3");
    host({ea ^ 7'h02, 3'd3}, 0, 1, 0, 1, 1, 1, "R4 wide miss bit4");
    host({ea, 3'd7}, 1, 0, 1, 0, 1, 1, "R8 aen read");
    host({ea, 3'd1}, 0, 1, 1, 1, 1, 1, "R8 aen write");

    // inactive base write keeps old window (R1)
    bridge_dis = 1;
    @(negedge clk); base_wr = 1; sd = 8'h00; settle();
    chk(xrd_n && xwr_n, "R1 disabled base write", {xrd_n, xwr_n}, 2'b11);
    host({ea, 3'd4}, 1, 0, 0, 0, 0, 1, "R1 disabled host");
    pass_chk(0, "R1 disabled");
    bridge_dis = 0;
    host({ea, 3'd4}, 1, 0, 0, 0, 1, 1, "R1 old base kept");

    // host read on the same edge as a new base write
    bcast(8'ha2, 1);
    host({ea, 3'd0}, 0, 1, 0, 0, 1, 1, "R12 after broadcast");

    for (int i = 0; i < 400; i++) begin
      logic [6:0] flip;
      bit rd, wr;
      int k = $urandom_range(0, 3);
      flip = (k == 0) ? 7'h00 : (k == 1) ? 7'h01 : 7'(1 << $urandom_range(1, 6));
      rd = 1'($urandom); wr = !rd && 1'($urandom);
      host({ea ^ flip, 3'($urandom)}, rd, wr, ($urandom_range(0, 4) == 0),
           1'($urandom), 1, 1, "R3 R4 R5 R6 random");
      if (i % 50 == 0) pass_chk(1, "random");
      if (i == 200) bcast(8'($urandom), 0);
    end

    idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule